// File: doc/BRIEF.md
# Checkpoint Rollback Register File

This block is the register file of a statically scheduled in-order core with one shadow copy added. A checkpoint strobe copies every architectural register into the shadow in a single clock edge. The same edge latches a recovery program counter and marks the shadow as valid. Later, an assert strobe arrives with a condition result that has been computed outside the block. A true result leaves everything alone. A false result puts the whole register file back to the shadow contents in one edge, and on the following cycle the block drives a redirect pulse that carries the saved recovery address to fetch.

Only one shadow copy exists, so each checkpoint overwrites the one before it. A rollback does not use up the shadow, so it stays available for later rollbacks. A false result that arrives while no shadow has been taken cannot roll anything back. In that case the block raises a one-cycle error pulse. The register file has two write ports and two combinational read ports, and register zero always reads as zero.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset, every register reads zero, no shadow is valid, and `redirect_valid`, `redirect_pc` and `rollback_err` are all zero.
- R2: Register 0 reads as zero on both read ports. A write to it has no effect.
- R3: A write is visible on the read ports from the cycle after its clock edge. When both write ports target the same register in the same cycle, port 1's data is kept.
- R4: A checkpoint copies all registers into the shadow, including writes made in the same cycle. It latches `ckpt_pc` and marks the shadow valid. A later checkpoint replaces both the copy and the address.
- R5: An assert with `chk_ok`=1 changes no register, does not touch the shadow, and produces no redirect and no error.
- R6: An assert with `chk_ok`=0 and a valid shadow restores every register from the shadow. Writes in that same cycle are discarded. `redirect_valid` is high for exactly the next cycle, with `redirect_pc` equal to the saved recovery address. `redirect_pc` is zero whenever `redirect_valid` is low.
- R7: An assert with `chk_ok`=0 and no valid shadow leaves the registers as they were and discards same-cycle writes. It raises `rollback_err` for exactly the next cycle and gives no redirect.
- R8: If a checkpoint and a failing assert share a cycle, the assert takes effect and the checkpoint is ignored: the shadow and the saved address keep their old values.
- R9: The shadow stays valid after a rollback. A second failing assert with no checkpoint in between restores the same contents and the same address.
- R10: `redirect_valid` and `rollback_err` are never high in the same cycle. Each is high only in the cycle after a failing assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we0 | input | 1 | Write enable, port 0 |
| wa0 | input | 5 | Write address, port 0 |
| wd0 | input | 32 | Write data, port 0 |
| we1 | input | 1 | Write enable, port 1 (wins on same address) |
| wa1 | input | 5 | Write address, port 1 |
| wd1 | input | 32 | Write data, port 1 |
| rs0 | input | 5 | Read address, port 0 |
| rd0 | output | 32 | Read data, port 0 |
| rs1 | input | 5 | Read address, port 1 |
| rd1 | output | 32 | Read data, port 1 |
| ckpt_en | input | 1 | Take a snapshot this cycle |
| ckpt_pc | input | 32 | Recovery address stored with the snapshot |
| chk_en | input | 1 | Assert evaluated this cycle |
| chk_ok | input | 1 | Condition result: 1 pass, 0 fail |
| redirect_valid | output | 1 | One-cycle fetch redirect after a rollback |
| redirect_pc | output | 32 | Recovery address while redirect is valid, else zero |
| rollback_err | output | 1 | One-cycle pulse: failing assert with no snapshot |

## Verification
Four properties are checked on every cycle. A redirect or error pulse must trace back to a failing assert, with the shadow in the matching state. The two pulses never overlap. After a rollback, each register must equal the shadow value from the edge before. With no checkpoint, the saved address must not change. Several behaviours depend on the order of operations, and only the bench's scenarios can show them. These are snapshots that include same-cycle writes, the priority of port 1 on a shared address, writes dropped on a failing assert, a checkpoint losing to a failing assert in the same cycle, and a second rollback from the same snapshot. A reference model compares both read ports and every output on each clock.

// File: rtl/ckpt_regfile.sv
module ckpt_regfile #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we0,
  input  logic [AW-1:0]   wa0,
  input  logic [XLEN-1:0] wd0,
  input  logic            we1,
  input  logic [AW-1:0]   wa1,
  input  logic [XLEN-1:0] wd1,
  input  logic [AW-1:0]   rs0,
  output logic [XLEN-1:0] rd0,
  input  logic [AW-1:0]   rs1,
  output logic [XLEN-1:0] rd1,
  input  logic            ckpt_en,
  input  logic [PCW-1:0]  ckpt_pc,
  input  logic            chk_en,
  input  logic            chk_ok,
  output logic            redirect_valid,
  output logic [PCW-1:0]  redirect_pc,
  output logic            rollback_err
);

  logic [XLEN-1:0] rf     [NREGS];
  logic [XLEN-1:0] rf_nxt [NREGS];
  logic [XLEN-1:0] shad   [NREGS];
  logic [PCW-1:0]  snap_pc;
  logic            snap_ok;

  wire fail    = chk_en & ~chk_ok;
  wire restore = fail & snap_ok;

  assign rd0 = (rs0 == '0) ? '0 : rf[rs0];
  assign rd1 = (rs1 == '0) ? '0 : rf[rs1];

  always_comb begin
    rf_nxt = rf;
    if (we0 && wa0 != '0) rf_nxt[wa0] = wd0;
    if (we1 && wa1 != '0) rf_nxt[wa1] = wd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        rf[i]   <= '0;
        shad[i] <= '0;
      end
      snap_pc        <= '0;
      snap_ok        <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      rollback_err   <= 1'b0;
    end else begin
      if (restore)    rf <= shad;
      else if (!fail) rf <= rf_nxt;
      if (ckpt_en && !fail) begin
        shad    <= rf_nxt;
        snap_pc <= ckpt_pc;
        snap_ok <= 1'b1;
      end
      redirect_valid <= restore;
      redirect_pc    <= restore ? snap_pc : '0;
      rollback_err   <= fail & ~snap_ok;
    end
  end

  assert_redirect_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(chk_en && !chk_ok && snap_ok));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_err |-> $past(chk_en && !chk_ok && !snap_ok));

  assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_valid && rollback_err));

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ckpt_en |=> $stable(snap_pc));

  for (genvar g = 0; g < NREGS; g++) begin : g_rst_chk
    assert_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !chk_ok && snap_ok) |=> rf[g] == $past(shad[g]));
  end

endmodule

// File: tb/tb_ckpt_regfile.sv
`timescale 1ns/1ps
module tb_ckpt_regfile;
  logic        clk = 0, rst_n = 0;
  logic        we0 = 0, we1 = 0, ckpt_en = 0, chk_en = 0, chk_ok = 0;
  logic [4:0]  wa0 = 0, wa1 = 0, rs0 = 0, rs1 = 0;
  logic [31:0] wd0 = 0, wd1 = 0, ckpt_pc = 0;
  logic [31:0] rd0, rd1, redirect_pc;
  logic        redirect_valid, rollback_err;

  ckpt_regfile dut (.clk, .rst_n, .we0, .wa0, .wd0, .we1, .wa1, .wd1,
    .rs0, .rd0, .rs1, .rd1, .ckpt_en, .ckpt_pc, .chk_en, .chk_ok,
    .redirect_valid, .redirect_pc, .rollback_err);

  always #2.5 clk = ~clk;

  logic [31:0] m_rf [32];
  logic [31:0] m_sh [32];
  logic [31:0] m_pc = 0, e_rpc = 0;
  bit m_sv = 0, e_rv = 0, e_err = 0;
  int vecs = 0, errs = 0;
  bit done = 0;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [31:0] nx [32];
    bit f = chk_en && !chk_ok;
    bit sv0 = m_sv;
    logic [31:0] pc0 = m_pc;
    nx = m_rf;
    if (we0 && wa0 != 0) nx[wa0] = wd0;
    if (we1 && wa1 != 0) nx[wa1] = wd1;
    if (f && sv0) m_rf = m_sh;
    else if (!f) m_rf = nx;
    if (ckpt_en && !f) begin m_sh = nx; m_pc = ckpt_pc; m_sv = 1; end
    e_rv  = f && sv0;
    e_rpc = (f && sv0) ? pc0 : 0;
    e_err = f && !sv0;
  endtask

  task automatic step(string tag);
    #0.5;
    cmp(tag, "rd0", rd0, (rs0 == 0) ? 32'h0 : m_rf[rs0]);
    cmp(tag, "rd1", rd1, (rs1 == 0) ? 32'h0 : m_rf[rs1]);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp(tag, "redirect_valid", {31'h0, redirect_valid}, {31'h0, e_rv});
    cmp(tag, "redirect_pc", redirect_pc, e_rpc);
    cmp(tag, "rollback_err", {31'h0, rollback_err}, {31'h0, e_err});
    we0 = 0; we1 = 0; ckpt_en = 0; chk_en = 0; chk_ok = 0;
  endtask

  task automatic wr(int p, int a, logic [31:0] d);
    if (p == 0) begin we0 = 1; wa0 = 5'(a); wd0 = d; end
    else begin we1 = 1; wa1 = 5'(a); wd1 = d; end
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 32; i++) begin
      rs0 = 5'(i); rs1 = 5'(31 - i);
      step(tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_rf[i] = 0; m_sh[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R1");
    // R7: failing assert, no snapshot yet, write dropped
    wr(0, 5, 32'hDEAD0005); chk_en = 1; chk_ok = 0; rs0 = 5; step("R7");
    rs0 = 5; step("R7");
    // R3: writes and same-address priority
    for (int i = 1; i < 32; i++) begin wr(0, i, 32'h1000 + i); wr(1, 32 - i, 32'h2000 + i); step("R3"); end
    wr(0, 9, 32'hAAAA0009); wr(1, 9, 32'hBBBB0009); rs0 = 9; step("R3");
    rs0 = 9; step("R3");
    // R2: write to register 0
    wr(0, 0, 32'hFFFFFFFF); wr(1, 0, 32'h12345678); rs0 = 0; rs1 = 0; step("R2");
    step("R2");
    // R4: checkpoint with same-cycle write
    wr(0, 7, 32'h77770007); ckpt_en = 1; ckpt_pc = 32'h0000_4000; step("R4");
    // R4: replaces previous snapshot
    wr(1, 8, 32'h88880008); ckpt_en = 1; ckpt_pc = 32'h0000_5000; step("R4");
    wr(0, 7, 32'h0BAD0007); wr(1, 8, 32'h0BAD0008); step("R4");
    // R5: passing assert
    chk_en = 1; chk_ok = 1; rs0 = 7; rs1 = 8; step("R5");
    rs0 = 7; rs1 = 8; step("R5");
    // R6: failing assert, write dropped, restore
    wr(0, 3, 32'h33333333); chk_en = 1; chk_ok = 0; step("R6");
    sweep("R6");
    // R9: second rollback from same snapshot
    wr(1, 7, 32'h99990007); step("R9");
    chk_en = 1; chk_ok = 0; step("R9");
    sweep("R9");
    // R8: checkpoint and failing assert in the same cycle
    wr(0, 4, 32'h44440004); step("R8");
    ckpt_en = 1; ckpt_pc = 32'h0000_6000; chk_en = 1; chk_ok = 0; step("R8");
    wr(0, 4, 32'h55550004); step("R8");
    chk_en = 1; chk_ok = 0; rs0 = 4; step("R8");
    rs0 = 4; step("R8");
    // R10: back-to-back failing asserts and mixed random traffic
    chk_en = 1; chk_ok = 0; step("R10");
    chk_en = 1; chk_ok = 0; step("R10");
    for (int n = 0; n < 600; n++) begin
      we0 = 1'($urandom); wa0 = 5'($urandom); wd0 = $urandom;
      we1 = 1'($urandom); wa1 = 5'($urandom); wd1 = $urandom;
      rs0 = 5'($urandom); rs1 = 5'($urandom);
      ckpt_en = ($urandom % 8) == 0; ckpt_pc = $urandom;
      chk_en = ($urandom % 6) == 0; chk_ok = 1'($urandom);
      step("R10");
    end
    // R1: reset again clears everything
    rst_n = 0;
    for (int i = 0; i < 32; i++) begin m_rf[i] = 0; m_sh[i] = 0; end
    m_sv = 0; m_pc = 0; e_rv = 0; e_rpc = 0; e_err = 0;
    @(negedge clk); rst_n = 1;
    sweep("R1");
    chk_en = 1; chk_ok = 0; step("R1");
    finish_run();
  end
endmodule